// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small programmable logic device. A fixed OR gate in the array delivers a sum-of-products term to the cell. The cell can pass that term through a polarity stage and drive it to the device pin. It can also hold the term in a flip-flop and drive the pin from there. A third option uses the pin only as an input. Whatever the choice, the cell returns one feedback signal to the AND array. That signal is taken from the flip-flop, from the cell's own pin, or from the pin of the neighbouring cell.

Three configuration bits choose the behaviour. Two of them are global: `cfg_reg_glb` and `cfg_alt_glb` are shared by every cell of a device. The third, `cfg_cell_sel`, belongs to this cell. Together `cfg_reg_glb` and `cfg_cell_sel` select one of four modes: registered output, combinational output, combinational I/O or dedicated input.

A device has eight such cells. The two at the ends of the row are built with `END_CELL = 1`. In those two cells the feedback multiplexer is steered by `cfg_alt_glb` in place of `cfg_reg_glb`. The clock and the active-low output enable `glb_oe_n` are common to all cells. The register is cleared by an asynchronous active-low reset.

Top module: `pld_macrocell`

## Requirements
- R1: Registered mode is selected by `cfg_reg_glb`=1 and `cfg_cell_sel`=0. In this mode `pin_oe` equals the inverse of `glb_oe_n`, and `pin_out` equals the register content.
- R2: On each rising clock edge the register loads `sum_in XOR cfg_invert`. In registered mode that value shows on `pin_out` one cycle after it was presented.
- R3: Combinational output mode is selected by `cfg_reg_glb`=0 and `cfg_cell_sel`=0. In this mode `pin_oe` is 1 and `pin_out` equals `sum_in XOR cfg_invert` in the same cycle.
- R4: Combinational I/O mode is selected by `cfg_reg_glb`=1 and `cfg_cell_sel`=1. In this mode `pin_oe` equals `oe_term` and `pin_out` equals `sum_in XOR cfg_invert`.
- R5: Dedicated input mode is selected by `cfg_reg_glb`=0 and `cfg_cell_sel`=1. In this mode `pin_oe` is 0 for every value of the other inputs.
- R6: The feedback select bit F is `cfg_reg_glb` when `END_CELL`=0. With F=1 and `cfg_cell_sel`=0, `fb_out` is the register content. With F=1 and `cfg_cell_sel`=1, `fb_out` is `pin_in`. With F=0, `fb_out` is `adj_pin_in`.
- R7: When `END_CELL`=1, F is `cfg_alt_glb`, and the mapping of R6 otherwise stays the same. The output mode still follows `cfg_reg_glb`.
- R8: While `rst_n` is 0 the register reads 0, with no clock edge needed. In registered mode `pin_out` and `fb_out` are then 0.
- R9: `glb_oe_n` has no effect on `pin_oe` in the three non-registered modes.
- R10: With `cfg_invert`=1 the combinational pin value is the complement of `sum_in`. With `cfg_invert`=0 it is `sum_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cells |
| rst_n | input | 1 | Asynchronous active-low register clear |
| cfg_reg_glb | input | 1 | Global select: registered-device bit, also feedback select in inner cells |
| cfg_alt_glb | input | 1 | Global select used by the feedback mux of end cells |
| cfg_cell_sel | input | 1 | Per-cell mode select bit |
| cfg_invert | input | 1 | Polarity: 1 inverts the OR term |
| sum_in | input | 1 | Sum-of-products term from the OR gate |
| oe_term | input | 1 | Product term used as pin enable in I/O mode |
| glb_oe_n | input | 1 | Shared active-low output enable for registered mode |
| pin_in | input | 1 | Value read back from this cell's pin |
| adj_pin_in | input | 1 | Value read from the neighbouring cell's pin |
| pin_out | output | 1 | Value presented to the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback to the AND array |

## Verification
Every cycle, the assertions check several rules. They check the pin enable that each decoded mode requires: the shared enable, the product-term enable, always on, or always off. They check that the feedback mux follows its decoded source. They also check that a registered pin shows the term captured one edge earlier. Only the bench scenarios can show the rest. These are the full mapping from raw configuration bits to modes, and the end-cell swap of the feedback select bit. They also include the fact that reset clears the register without a clock edge, and the absence of any effect of `glb_oe_n` outside registered mode. The bench establishes all of these by sweeping every input combination on an inner cell and an end cell.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MODE_REG      = 2'd0,
        MODE_COMB_OUT = 2'd1,
        MODE_COMB_IO  = 2'd2,
        MODE_INPUT    = 2'd3
    } mc_mode_e;

    typedef enum logic [1:0] {
        FB_REG     = 2'd0,
        FB_OWN_PIN = 2'd1,
        FB_ADJ_PIN = 2'd2
    } mc_fb_e;

    typedef struct packed {
        logic q;
    } mc_state_t;

    function automatic mc_mode_e decode_mode(input logic reg_glb, input logic cell_sel);
        mc_mode_e m;
        case ({reg_glb, cell_sel})
            2'b10:   m = MODE_REG;
            2'b11:   m = MODE_COMB_IO;
            2'b00:   m = MODE_COMB_OUT;
            default: m = MODE_INPUT;
        endcase
        return m;
    endfunction

    function automatic mc_fb_e decode_fb(input logic fb_glb, input logic cell_sel);
        mc_fb_e f;
        if (!fb_glb)       f = FB_ADJ_PIN;
        else if (cell_sel) f = FB_OWN_PIN;
        else               f = FB_REG;
        return f;
    endfunction

endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
    import pld_mc_pkg::*;
#(
    parameter bit END_CELL = 1'b0
) (
    input  logic     cfg_reg_glb,
    input  logic     cfg_alt_glb,
    input  logic     cfg_cell_sel,
    output mc_mode_e out_mode,
    output mc_fb_e   fb_src
);

    logic fb_glb;

    generate
        if (END_CELL) begin : g_end_sel
            assign fb_glb = cfg_alt_glb;
        end else begin : g_inner_sel
            logic unused_alt;
            assign unused_alt = cfg_alt_glb;
            assign fb_glb     = cfg_reg_glb;
        end
    endgenerate

    always_comb begin
        out_mode = decode_mode(cfg_reg_glb, cfg_cell_sel);
        fb_src   = decode_fb(fb_glb, cfg_cell_sel);
    end

endmodule

// File: rtl/mc_drive.sv
module mc_drive
    import pld_mc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  mc_mode_e out_mode,
    input  logic     term_pol,
    input  logic     reg_q,
    input  logic     oe_term,
    input  logic     glb_oe_n,
    output logic     pin_out,
    output logic     pin_oe
);

    always_comb begin
        pin_out = term_pol;
        pin_oe  = 1'b0;
        case (out_mode)
            MODE_REG: begin
                pin_out = reg_q;
                pin_oe  = ~glb_oe_n;
            end
            MODE_COMB_OUT: begin
                pin_oe  = 1'b1;
            end
            MODE_COMB_IO: begin
                pin_oe  = oe_term;
            end
            default: begin
                pin_oe  = 1'b0;
            end
        endcase
    end

    AST_REG_SHARED_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == MODE_REG) |-> (pin_oe == !glb_oe_n)); // R1
    AST_COMB_OUT_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == MODE_COMB_OUT) |-> pin_oe); // R3
    AST_IO_TERM_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == MODE_COMB_IO) |-> (pin_oe == oe_term)); // R4
    AST_INPUT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == MODE_INPUT) |-> !pin_oe); // R5

endmodule

// File: rtl/mc_fb_mux.sv
module mc_fb_mux
    import pld_mc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mc_fb_e fb_src,
    input  logic   reg_q,
    input  logic   pin_in,
    input  logic   adj_pin_in,
    output logic   fb_out
);

    always_comb begin
        case (fb_src)
            FB_REG:     fb_out = reg_q;
            FB_OWN_PIN: fb_out = pin_in;
            default:    fb_out = adj_pin_in;
        endcase
    end

    AST_FB_ADJ_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_src == FB_ADJ_PIN) |-> (fb_out == adj_pin_in)); // R6
    AST_FB_PIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_src == FB_OWN_PIN) |-> (fb_out == pin_in)); // R6

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter bit END_CELL  = 1'b0,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_reg_glb,
    input  logic cfg_alt_glb,
    input  logic cfg_cell_sel,
    input  logic cfg_invert,
    input  logic sum_in,
    input  logic oe_term,
    input  logic glb_oe_n,
    input  logic pin_in,
    input  logic adj_pin_in,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out
);

    mc_mode_e  out_mode;
    mc_fb_e    fb_src;
    logic      term_pol;
    mc_state_t st_d;
    mc_state_t st_q;

    mc_mode_decode #(
        .END_CELL (END_CELL)
    ) u_decode (
        .cfg_reg_glb  (cfg_reg_glb),
        .cfg_alt_glb  (cfg_alt_glb),
        .cfg_cell_sel (cfg_cell_sel),
        .out_mode     (out_mode),
        .fb_src       (fb_src)
    );

    always_comb begin
        term_pol = sum_in ^ cfg_invert;
        st_d     = st_q;
        st_d.q   = term_pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.q <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    mc_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_mode (out_mode),
        .term_pol (term_pol),
        .reg_q    (st_q.q),
        .oe_term  (oe_term),
        .glb_oe_n (glb_oe_n),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    mc_fb_mux u_fb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_src     (fb_src),
        .reg_q      (st_q.q),
        .pin_in     (pin_in),
        .adj_pin_in (adj_pin_in),
        .fb_out     (fb_out)
    );

    AST_REG_PIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!(cfg_reg_glb && !cfg_cell_sel) || (pin_out == $past(sum_in ^ cfg_invert)))); // R2

endmodule

// File: tb/pld_macrocell_tb.sv
`timescale 1ns/1ps
module pld_macrocell_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_reg_glb = 1'b1, cfg_alt_glb = 1'b0, cfg_cell_sel = 1'b0, cfg_invert = 1'b0;
    logic sum_in = 1'b1, oe_term = 1'b0, glb_oe_n = 1'b0, pin_in = 1'b0, adj_pin_in = 1'b0;
    logic out_a, oe_a, fb_a;
    logic out_b, oe_b, fb_b;

    int n_checks = 0;
    int n_fail   = 0;
    logic q_m = 1'b0;

    always #5 clk = ~clk;

    pld_macrocell #(.END_CELL(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_reg_glb(cfg_reg_glb), .cfg_alt_glb(cfg_alt_glb),
        .cfg_cell_sel(cfg_cell_sel), .cfg_invert(cfg_invert), .sum_in(sum_in),
        .oe_term(oe_term), .glb_oe_n(glb_oe_n), .pin_in(pin_in), .adj_pin_in(adj_pin_in),
        .pin_out(out_a), .pin_oe(oe_a), .fb_out(fb_a)
    );

    pld_macrocell #(.END_CELL(1'b1)) u_dut_end (
        .clk(clk), .rst_n(rst_n), .cfg_reg_glb(cfg_reg_glb), .cfg_alt_glb(cfg_alt_glb),
        .cfg_cell_sel(cfg_cell_sel), .cfg_invert(cfg_invert), .sum_in(sum_in),
        .oe_term(oe_term), .glb_oe_n(glb_oe_n), .pin_in(pin_in), .adj_pin_in(adj_pin_in),
        .pin_out(out_b), .pin_oe(oe_b), .fb_out(fb_b)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_fb(input logic sel, input logic q);
        if (!sel)         return adj_pin_in;
        if (cfg_cell_sel) return pin_in;
        return q;
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic pol;
        logic exp_oe;
        // R8: reset state with registered config and active term
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R8 reset pin_out", out_a, 1'b0);
        check("R8 reset fb_out", fb_a, 1'b0);
        check("R8 reset end pin_out", out_b, 1'b0);
        rst_n = 1'b1;
        q_m   = 1'b0;

        for (int v = 0; v < 512; v++) begin
            @(negedge clk);
            {cfg_reg_glb, cfg_alt_glb, cfg_cell_sel, cfg_invert, sum_in,
             oe_term, glb_oe_n, pin_in, adj_pin_in} = v[8:0];
            #1;
            pol = sum_in ^ cfg_invert;
            case ({cfg_reg_glb, cfg_cell_sel})
                2'b10: begin
                    exp_oe = ~glb_oe_n;
                    check("R1 reg oe", oe_a, exp_oe);
                    check("R2 reg pin_out", out_a, q_m);
                    check("R1 R7 end reg oe", oe_b, exp_oe);
                end
                2'b00: begin
                    check("R3 R9 comb oe", oe_a, 1'b1);
                    check("R3 R10 comb out", out_a, pol);
                    check("R3 R7 end comb out", out_b, pol);
                end
                2'b11: begin
                    check("R4 R9 io oe", oe_a, oe_term);
                    check("R4 R10 io out", out_a, pol);
                    check("R4 R7 end io oe", oe_b, oe_term);
                end
                default: begin
                    check("R5 R9 input oe", oe_a, 1'b0);
                    check("R5 R7 end input oe", oe_b, 1'b0);
                end
            endcase
            check("R6 fb inner", fb_a, exp_fb(cfg_reg_glb, q_m));
            check("R7 fb end", fb_b, exp_fb(cfg_alt_glb, q_m));
            @(posedge clk);
            q_m = pol;
        end

        // R2 then R8: load a 1, then clear asynchronously mid-cycle
        @(negedge clk);
        {cfg_reg_glb, cfg_alt_glb, cfg_cell_sel, cfg_invert, sum_in, glb_oe_n} = 6'b110010;
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R2 reg loads 1", out_a, 1'b1);
        check("R2 reg fb loads 1", fb_a, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R8 async clear pin_out", out_a, 1'b0);
        check("R8 async clear end fb", fb_b, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule